// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command interpreter of a parallel NOR flash. It watches bus write cycles. A cycle counts when the write strobe rises while chip enable is high, and the block takes the address and data present at that edge. It matches the cycles against fixed unlock-and-command sequences. When a sequence completes, the block raises a one-cycle start pulse for the operation that the embedded controller should run. It also keeps the current operating mode. It exposes the latched program address and data, and a mask of the sectors selected for erase.

Any cycle that breaks a sequence returns the decoder to read-array mode without issuing anything. While an operation runs, every command is ignored except erase suspend and reset. The embedded controller reports the end of an operation on `opDone`. Several sectors can be queued for one erase: further sector-erase cycles are accepted inside a short window, and the erase start pulse fires only when that window closes.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), every start pulse is low, `sectorMask` is 0, and `progAddr` and `progData` are 0.
- R2: The cycles AAh@555h, 55h@2AAh, A0h@555h followed by one cycle at any address raise `startProgram` for one cycle. In that cycle `progAddr` and `progData` hold the fourth cycle's address and data, and `mode` becomes 2 (busy).
- R3: The cycles AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `startChipErase`, set every bit of `sectorMask` and make `mode` 2.
- R4: The same five erase-prefix cycles followed by 30h at any address make `mode` 2 and set `sectorMask` to only the bit of that sector. The sector index is the top SECT_BITS bits of the address. Each further 30h cycle adds its sector and restarts the window. `startSectorErase` rises exactly WIN_CYC cycles after the last accepted 30h cycle.
- R5: A cycle with data other than 30h inside the sector window clears `sectorMask`, returns `mode` to 0, and `startSectorErase` never fires.
- R6: A wrong address, wrong data or wrong order anywhere in a sequence returns the decoder to the idle read state without any pulse. A correct sequence starting afterwards works.
- R7: The cycles AAh@555h, 55h@2AAh, 90h@555h raise `enterAutoselect` and make `mode` 1. In that mode, writes other than F0h are ignored.
- R8: A single F0h cycle at any address, in any mode, raises `resetCmd` and returns `mode` to 0. At most one start or command pulse is high in any cycle.
- R9: In mode 2, unlock and command sequences are ignored. An `opDone` high in a cycle with no accepted write and no open sector window returns `mode` to 0.
- R10: B0h during a running sector erase raises `eraseSuspend` and makes `mode` 3. In mode 3, 30h raises `eraseResume` and makes `mode` 2. B0h during a chip erase or a program has no effect.
- R11: A write counts once per rising edge of `writeEn` with `chipEn` high. Holding `writeEn` high adds no cycles, and an edge with `chipEn` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Chip enable; qualifies the write strobe |
| writeEn | input | 1 | Write strobe; its rising edge captures a bus cycle |
| busAddr | input | ADDR_W | Bus address |
| busData | input | 8 | Bus data / command byte |
| opDone | input | 1 | Embedded operation finished |
| startProgram | output | 1 | One-cycle program start |
| startChipErase | output | 1 | One-cycle chip erase start |
| startSectorErase | output | 1 | One-cycle sector erase start, at window close |
| enterAutoselect | output | 1 | One-cycle autoselect entry |
| eraseSuspend | output | 1 | One-cycle erase suspend |
| eraseResume | output | 1 | One-cycle erase resume |
| resetCmd | output | 1 | One-cycle reset command |
| mode | output | 2 | 0 read, 1 autoselect, 2 busy, 3 erase suspended |
| progAddr | output | ADDR_W | Latched program address |
| progData | output | 8 | Latched program data |
| sectorMask | output | 2**SECT_BITS | Sectors selected for erase |

## Verification
Every pulse, mode change, program latch and mask update is registered at the clock edge that sees the strobe's rising edge. All of them are due one cycle after the strobe is raised. The bench drives inputs on the falling edge and reads results on the next falling edge. Pulses are also collected by an accumulator on every falling edge, so a missing or stray pulse is caught even between samples. The sector-erase start is due WIN_CYC cycles after the last 30h cycle. The bench counts falling edges from the sample point of that cycle until the pulse appears, and compares the count with WIN_CYC exactly.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int CMD_W = 8;

  localparam logic [10:0] UNLOCK_A1 = 11'h555;
  localparam logic [10:0] UNLOCK_A2 = 11'h2AA;

  localparam logic [CMD_W-1:0] D_UNLOCK1 = 8'hAA;
  localparam logic [CMD_W-1:0] D_UNLOCK2 = 8'h55;
  localparam logic [CMD_W-1:0] D_PROG    = 8'hA0;
  localparam logic [CMD_W-1:0] D_ERASE   = 8'h80;
  localparam logic [CMD_W-1:0] D_CHIP    = 8'h10;
  localparam logic [CMD_W-1:0] D_SECTOR  = 8'h30;
  localparam logic [CMD_W-1:0] D_SUSPEND = 8'hB0;
  localparam logic [CMD_W-1:0] D_RESUME  = 8'h30;
  localparam logic [CMD_W-1:0] D_AUTOSEL = 8'h90;
  localparam logic [CMD_W-1:0] D_RESET   = 8'hF0;

  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BUSY    = 2'd2,
    MODE_SUSP    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_UNL1, SEQ_UNL2, SEQ_PROG, SEQ_ERS, SEQ_EUNL1, SEQ_EUNL2
  } seq_e;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic autosel;
    logic susp;
    logic resume;
    logic rst;
  } pulse_t;

  typedef struct packed {
    logic loadProg;
    logic clearSect;
    logic fillSect;
    logic addSect;
  } dpStrobe_t;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             writeEn,
  input  logic [10:0]      addrLow,
  input  logic [CMD_W-1:0] busData,
  input  logic             opDone,
  output pulse_t           pulses,
  output mode_e            mode,
  output dpStrobe_t        strobe
);

  localparam int CNT_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;

  logic       weD;
  mode_e      modeQ, nMode;
  seq_e       seqQ, nSeq;
  logic       winQ, nWin;
  logic       sectOpQ, nSectOp;
  logic [CNT_W-1:0] cntQ, nCnt;
  pulse_t     pulseQ, nPulse;

  logic hit, isUnl1, isUnl2, at555;

  assign hit    = chipEn && writeEn && !weD;
  assign at555  = (addrLow == UNLOCK_A1);
  assign isUnl1 = at555 && (busData == D_UNLOCK1);
  assign isUnl2 = (addrLow == UNLOCK_A2) && (busData == D_UNLOCK2);

  always_comb begin
    nMode   = modeQ;
    nSeq    = seqQ;
    nWin    = winQ;
    nCnt    = cntQ;
    nSectOp = sectOpQ;
    nPulse  = '0;
    strobe  = '0;
    if (hit) begin
      if (busData == D_RESET) begin
        nPulse.rst = 1'b1;
        nMode      = MODE_READ;
        nSeq       = SEQ_IDLE;
        nWin       = 1'b0;
        nSectOp    = 1'b0;
        if (winQ) strobe.clearSect = 1'b1;
      end else begin
        unique case (modeQ)
          MODE_READ: begin
            unique case (seqQ)
              SEQ_IDLE:  if (isUnl1) nSeq = SEQ_UNL1;
              SEQ_UNL1:  nSeq = isUnl2 ? SEQ_UNL2 : SEQ_IDLE;
              SEQ_UNL2: begin
                nSeq = SEQ_IDLE;
                if (at555) begin
                  if (busData == D_PROG) nSeq = SEQ_PROG;
                  else if (busData == D_ERASE) nSeq = SEQ_ERS;
                  else if (busData == D_AUTOSEL) begin
                    nPulse.autosel = 1'b1;
                    nMode          = MODE_AUTOSEL;
                  end
                end
              end
              SEQ_PROG: begin
                nSeq            = SEQ_IDLE;
                nPulse.prog     = 1'b1;
                strobe.loadProg = 1'b1;
                nMode           = MODE_BUSY;
                nSectOp         = 1'b0;
              end
              SEQ_ERS:   nSeq = isUnl1 ? SEQ_EUNL1 : SEQ_IDLE;
              SEQ_EUNL1: nSeq = isUnl2 ? SEQ_EUNL2 : SEQ_IDLE;
              SEQ_EUNL2: begin
                nSeq = SEQ_IDLE;
                if (at555 && busData == D_CHIP) begin
                  nPulse.chip     = 1'b1;
                  strobe.fillSect = 1'b1;
                  nMode           = MODE_BUSY;
                  nSectOp         = 1'b0;
                end else if (busData == D_SECTOR) begin
                  strobe.clearSect = 1'b1;
                  strobe.addSect   = 1'b1;
                  nMode            = MODE_BUSY;
                  nWin             = 1'b1;
                  nCnt             = CNT_W'(WIN_CYC - 1);
                  nSectOp          = 1'b1;
                end
              end
              default: nSeq = SEQ_IDLE;
            endcase
          end
          MODE_AUTOSEL: ;
          MODE_BUSY: begin
            if (winQ) begin
              if (busData == D_SECTOR) begin
                strobe.addSect = 1'b1;
                nCnt           = CNT_W'(WIN_CYC - 1);
              end else begin
                strobe.clearSect = 1'b1;
                nWin             = 1'b0;
                nMode            = MODE_READ;
                nSectOp          = 1'b0;
              end
            end else if (busData == D_SUSPEND && sectOpQ) begin
              nPulse.susp = 1'b1;
              nMode       = MODE_SUSP;
            end
          end
          MODE_SUSP: begin
            if (busData == D_RESUME) begin
              nPulse.resume = 1'b1;
              nMode         = MODE_BUSY;
            end
          end
          default: ;
        endcase
      end
    end else if (winQ) begin
      if (cntQ == '0) begin
        nPulse.sect = 1'b1;
        nWin        = 1'b0;
      end else begin
        nCnt = cntQ - 1'b1;
      end
    end else if (modeQ == MODE_BUSY && opDone) begin
      nMode   = MODE_READ;
      nSectOp = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weD     <= 1'b0;
      modeQ   <= MODE_READ;
      seqQ    <= SEQ_IDLE;
      winQ    <= 1'b0;
      sectOpQ <= 1'b0;
      cntQ    <= '0;
      pulseQ  <= '0;
    end else begin
      weD     <= writeEn;
      modeQ   <= nMode;
      seqQ    <= nSeq;
      winQ    <= nWin;
      sectOpQ <= nSectOp;
      cntQ    <= nCnt;
      pulseQ  <= nPulse;
    end
  end

  assign pulses = pulseQ;
  assign mode   = modeQ;

  a_r2_prog_busy: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ.prog |-> modeQ == MODE_BUSY);
  a_r10_suspend_mode: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ.susp |-> modeQ == MODE_SUSP);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseQ));
  a_r4_window_busy: assert property (@(posedge clk) disable iff (!rstN)
    winQ |-> modeQ == MODE_BUSY);
  a_r11_no_edge_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> (pulseQ.prog == 1'b0 && pulseQ.rst == 1'b0 && pulseQ.autosel == 1'b0));

endmodule

// File: rtl/nor_cmd_datapath.sv
module nor_cmd_datapath
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [CMD_W-1:0]       busData,
  output logic [ADDR_W-1:0]      progAddr,
  output logic [CMD_W-1:0]       progData,
  output logic [(1<<SECT_BITS)-1:0] sectorMask
);

  localparam int NUM_SECT = 1 << SECT_BITS;

  logic [SECT_BITS-1:0] sectIdx;
  logic [NUM_SECT-1:0]  maskQ;

  assign sectIdx = busAddr[ADDR_W-1 -: SECT_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strobe.loadProg) begin
      progAddr <= busAddr;
      progData <= busData;
    end
  end

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    logic selHere;
    assign selHere = strobe.addSect && (sectIdx == SECT_BITS'(i));
    always_ff @(posedge clk) begin
      if (!rstN)                 maskQ[i] <= 1'b0;
      else if (strobe.fillSect)  maskQ[i] <= 1'b1;
      else if (strobe.clearSect) maskQ[i] <= selHere;
      else if (selHere)          maskQ[i] <= 1'b1;
    end
  end

  assign sectorMask = maskQ;

  a_r3_fill_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillSect |=> &maskQ);
  a_r4_clear_add: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearSect && !strobe.addSect && !strobe.fillSect) |=> maskQ == '0);

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SECT_BITS = 4,
  parameter int WIN_CYC   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      chipEn,
  input  logic                      writeEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [7:0]                busData,
  input  logic                      opDone,
  output logic                      startProgram,
  output logic                      startChipErase,
  output logic                      startSectorErase,
  output logic                      enterAutoselect,
  output logic                      eraseSuspend,
  output logic                      eraseResume,
  output logic                      resetCmd,
  output logic [1:0]                mode,
  output logic [ADDR_W-1:0]         progAddr,
  output logic [7:0]                progData,
  output logic [(1<<SECT_BITS)-1:0] sectorMask
);

  pulse_t    pulses;
  mode_e     modeS;
  dpStrobe_t strobe;

  nor_cmd_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .writeEn(writeEn),
    .addrLow(busAddr[10:0]), .busData(busData), .opDone(opDone),
    .pulses(pulses), .mode(modeS), .strobe(strobe)
  );

  nor_cmd_datapath #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busData(busData), .progAddr(progAddr), .progData(progData),
    .sectorMask(sectorMask)
  );

  assign startProgram     = pulses.prog;
  assign startChipErase   = pulses.chip;
  assign startSectorErase = pulses.sect;
  assign enterAutoselect  = pulses.autosel;
  assign eraseSuspend     = pulses.susp;
  assign eraseResume      = pulses.resume;
  assign resetCmd         = pulses.rst;
  assign mode             = modeS;

endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

  localparam int ADDR_W = 16;
  localparam int SECT_BITS = 4;
  localparam int WIN_CYC = 16;
  localparam int NS = 1 << SECT_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0;
  logic writeEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic opDone = 1'b0;
  logic startProgram, startChipErase, startSectorErase, enterAutoselect;
  logic eraseSuspend, eraseResume, resetCmd;
  logic [1:0] mode;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0] progData;
  logic [NS-1:0] sectorMask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [6:0] seen = '0;

  always #2.5 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .WIN_CYC(WIN_CYC)) uut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .writeEn(writeEn),
    .busAddr(busAddr), .busData(busData), .opDone(opDone),
    .startProgram(startProgram), .startChipErase(startChipErase),
    .startSectorErase(startSectorErase), .enterAutoselect(enterAutoselect),
    .eraseSuspend(eraseSuspend), .eraseResume(eraseResume), .resetCmd(resetCmd),
    .mode(mode), .progAddr(progAddr), .progData(progData), .sectorMask(sectorMask)
  );

  // bit order: prog chip sect autosel susp resume rst
  localparam int P_PROG = 6, P_CHIP = 5, P_SECT = 4, P_AUTO = 3, P_SUSP = 2, P_RES = 1, P_RST = 0;

  function automatic logic [6:0] pv();
    return {startProgram, startChipErase, startSectorErase, enterAutoselect,
            eraseSuspend, eraseResume, resetCmd};
  endfunction

  function automatic logic [NS-1:0] sectBit(input logic [ADDR_W-1:0] a);
    return NS'(1) << a[ADDR_W-1 -: SECT_BITS];
  endfunction

  always @(negedge clk) begin
    cycles++;
    seen <= seen | pv();
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                    input bit ce = 1'b1, input int hold = 1);
    @(negedge clk);
    busAddr = a; busData = d; chipEn = ce; writeEn = 1'b1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    writeEn = 1'b0; chipEn = 1'b0;
  endtask

  task automatic clrSeen();
    @(negedge clk);
    seen = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic done();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic eraseHead();
    unlock(); wr(16'h0555, 8'h80); unlock();
  endtask

  task automatic waitSect(output int n);
    n = 0;
    while (!startSectorErase && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    logic [NS-1:0] expMask;
    logic [ADDR_W-1:0] a;
    logic [7:0] d;
    n = $urandom(32'd4242);

    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode == 2'd0, "R1 mode", mode, 0);
    chk(pv() == 7'd0, "R1 pulses", pv(), 0);
    chk(sectorMask == '0 && progAddr == '0 && progData == '0, "R1 regs", sectorMask, 0);

    // R11 chip enable low ignored
    clrSeen();
    wr(16'h0555, 8'hAA, 1'b0);
    wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h1234, 8'h5A);
    idle(2);
    chk(seen == 7'd0 && mode == 2'd0, "R11 ce low", seen, 0);

    // R11 held strobe counts once, then R2 program
    clrSeen();
    wr(16'h0555, 8'hAA, 1'b1, 4);
    wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0);
    wr(16'h4321, 8'h5A);
    chk(startProgram == 1'b1, "R2 R11 program pulse", startProgram, 1);
    chk(progAddr == 16'h4321 && progData == 8'h5A, "R2 latch", {progAddr, progData}, 24'h43215A);
    chk(mode == 2'd2, "R2 busy", mode, 2);
    // R9 commands ignored while busy
    clrSeen();
    unlock(); wr(16'h0555, 8'h90); wr(16'h0555, 8'hB0);
    idle(2);
    chk(seen == 7'd0 && mode == 2'd2, "R9 ignored busy", {seen, mode}, 2);
    done();
    @(negedge clk);
    chk(mode == 2'd0, "R9 opDone", mode, 0);

    // R6 wrong address, wrong data, wrong order
    clrSeen();
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h11);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h54); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h11);
    wr(16'h02AA, 8'h55); wr(16'h0555, 8'hAA); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h11);
    idle(2);
    chk(seen == 7'd0 && mode == 2'd0, "R6 aborted", seen, 0);
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0777, 8'h3C);
    chk(startProgram && progAddr == 16'h0777, "R6 recovery", progAddr, 16'h0777);
    done();

    // R7 autoselect and R8 reset
    unlock(); wr(16'h0555, 8'h90);
    chk(enterAutoselect && mode == 2'd1, "R7 autoselect", {enterAutoselect, mode}, 3'b101);
    clrSeen();
    unlock(); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h22);
    idle(2);
    chk(seen == 7'd0 && mode == 2'd1, "R7 ignored", {seen, mode}, 1);
    wr(16'h0ABC, 8'hF0);
    chk(resetCmd && mode == 2'd0, "R8 reset from autoselect", {resetCmd, mode}, 3'b100);

    // R3 chip erase, R10 suspend ignored
    eraseHead(); wr(16'h0555, 8'h10);
    chk(startChipErase && mode == 2'd2, "R3 chip start", {startChipErase, mode}, 3'b110);
    chk(&sectorMask, "R3 mask", sectorMask, {NS{1'b1}});
    clrSeen();
    wr(16'h0000, 8'hB0); idle(2);
    chk(seen == 7'd0 && mode == 2'd2, "R10 no suspend on chip erase", {seen, mode}, 2);
    done();

    // R4 multi-sector erase with window timing
    clrSeen();
    eraseHead(); wr(16'h3000, 8'h30);
    chk(mode == 2'd2 && sectorMask == sectBit(16'h3000), "R4 first sector", sectorMask, sectBit(16'h3000));
    wr(16'h7000, 8'h30); wr(16'hC123, 8'h30);
    waitSect(n);
    chk(n == WIN_CYC, "R4 window cycles", n, WIN_CYC);
    expMask = sectBit(16'h3000) | sectBit(16'h7000) | sectBit(16'hC123);
    chk(sectorMask == expMask, "R4 mask", sectorMask, expMask);
    chk(seen[P_SECT] == 1'b0 || n == WIN_CYC, "R4 no early start", seen, 0);

    // R10 suspend/resume
    wr(16'h0000, 8'hB0);
    chk(eraseSuspend && mode == 2'd3, "R10 suspend", {eraseSuspend, mode}, 3'b111);
    clrSeen();
    wr(16'h02AA, 8'h55); idle(2);
    chk(seen == 7'd0 && mode == 2'd3, "R10 ignored in suspend", {seen, mode}, 3);
    wr(16'h0000, 8'h30);
    chk(eraseResume && mode == 2'd2, "R10 resume", {eraseResume, mode}, 3'b110);
    wr(16'h0000, 8'hF0);
    chk(resetCmd && mode == 2'd0, "R8 reset from busy", {resetCmd, mode}, 3'b100);

    // R5 abandon inside window
    clrSeen();
    eraseHead(); wr(16'h5000, 8'h30); wr(16'h5000, 8'h80);
    chk(mode == 2'd0 && sectorMask == '0, "R5 abandon", {mode, sectorMask}, 0);
    idle(WIN_CYC + 4);
    chk(seen == 7'd0, "R5 no start", seen, 0);

    // random programs with garbage writes mixed in
    for (int it = 0; it < 12; it++) begin
      clrSeen();
      for (int g = 0; g < 4; g++) begin
        d = 8'($urandom);
        if (d == 8'hAA || d == 8'hF0) d = 8'h12;
        wr(16'($urandom), d);
      end
      idle(2);
      chk(seen == 7'd0 && mode == 2'd0, "R6 garbage ignored", seen, 0);
      a = 16'($urandom); d = 8'($urandom);
      unlock(); wr(16'h0555, 8'hA0); wr(a, d);
      chk(startProgram && progAddr == a && progData == d, "R2 random program",
          {progAddr, progData}, {a, d});
      done();
    end

    // random sector sets
    for (int it = 0; it < 6; it++) begin
      int k;
      k = 1 + int'($urandom % 3);
      expMask = '0;
      eraseHead();
      for (int j = 0; j < k; j++) begin
        a = 16'($urandom);
        expMask |= sectBit(a);
        wr(a, 8'h30);
      end
      waitSect(n);
      chk(n == WIN_CYC && sectorMask == expMask, "R4 random sectors", sectorMask, expMask);
      done();
      @(negedge clk);
      chk(mode == 2'd0, "R9 opDone after erase", mode, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule